// File: doc/BRIEF.md
# Hardware Loop Controller

This block gives a small sequencer one level of hardware looping that costs no branch cycles. When the fetch logic executes a loop-setup instruction, it pulses a start strobe together with a count code, a register byte and a signed 8-bit offset. The controller then records the address of the first loop instruction (current address plus one), the address of the last loop instruction (current address plus the offset) and an iteration count.

On every cycle the controller compares the address of the executing instruction with the stored last address. While iterations remain, a match replaces the sequential next address with the first loop address in the same cycle, so the loop-back adds no delay. On the final pass the sequential next address goes through unchanged and the loop disarms. Only one loop can be live. A new setup replaces whatever loop is in progress. The instruction at the last loop address must not itself change the flow of control; the controller does not check this.

Top module: `hw_loop_ctrl`

## Requirements
- R1: During reset and after it is released, `loop_busy` is 0 and `next_pc` equals `seq_pc`.
- R2: On a cycle with `setup` high, the controller records a first address of `cur_pc + 1` and a last address of `cur_pc + sext(rel_off)`. `rel_off` is two's complement, so 8'h80 places the last address 128 below `cur_pc`.
- R3: `cnt_code` 0 takes the count from `reg_lo`, which is the low byte of a register. `cnt_code` values 1 to 7 give a count of 2 raised to `cnt_code`.
- R4: While a loop is armed and more than one pass remains, a cycle with `cur_pc` equal to the last address drives `next_pc` to the first address in that same cycle and uses up one pass.
- R5: On the last pass, `next_pc` equals `seq_pc` at the last address and `loop_busy` falls on the following cycle. The body therefore runs exactly the loaded count of times.
- R6: A register count of 0 leaves the loop disarmed: `loop_busy` stays 0 and the body runs once.
- R7: A setup while a loop is armed replaces the first address, the last address and the count.
- R8: When no loop is armed, or `cur_pc` differs from the last address, `next_pc` equals `seq_pc`.
- R9: On a setup cycle `next_pc` equals `seq_pc`, even if `cur_pc` equals the old last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 16 | Address of the executing instruction |
| seq_pc | input | 16 | Next address the sequencer would use without looping |
| setup | input | 1 | Loop-setup instruction executes this cycle |
| cnt_code | input | 3 | Count source: 0 = register byte, 1..7 = power-of-two exponent |
| reg_lo | input | 8 | Low byte of the count register |
| rel_off | input | 8 | Signed offset from `cur_pc` to the last loop instruction |
| next_pc | output | 16 | Next fetch address after the loop override |
| loop_busy | output | 1 | A loop is armed |

## Verification
If the stored count is wrong, the iteration count at the loop-back address changes. The error shows at `next_pc` on the final pass, or one pass early, and `loop_busy` falls at the wrong time. If a stored address is wrong, `next_pc` redirects at the wrong address or to the wrong address the first time the body ends, which is within a few cycles of setup. The bench runs a reference that steps the program counter itself and compares both outputs on every cycle, so any such difference appears in the cycle it happens.

// File: rtl/hw_loop_pkg.sv
package hw_loop_pkg;
  // Action the loop logic takes this cycle
  typedef enum logic [1:0] {
    LP_HOLD = 2'd0,
    LP_LOAD = 2'd1,
    LP_STEP = 2'd2,
    LP_DONE = 2'd3
  } lp_op_e;
endpackage

// File: rtl/hw_loop_bounds.sv
module hw_loop_bounds
  import hw_loop_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lp_op_e        op,
  input  logic [AW-1:0] cur_pc,
  input  logic [OW-1:0] rel_off,
  output logic [AW-1:0] first_q,
  output logic          at_last
);
  localparam int EXT = AW - OW;

  logic [AW-1:0] last_q;
  logic [AW-1:0] first_d, last_d;
  logic          cap_en;

  always_comb begin
    cap_en  = (op == LP_LOAD);
    first_d = cur_pc + AW'(1);
    last_d  = cur_pc + {{EXT{rel_off[OW-1]}}, rel_off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (cap_en) begin
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign at_last = (cur_pc == last_q);

  // R2: first address follows the setup address by one
  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LP_LOAD) |=> (first_q == $past(cur_pc) + AW'(1)));
endmodule

// File: rtl/hw_loop_count.sv
module hw_loop_count
  import hw_loop_pkg::*;
#(
  parameter int CW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lp_op_e        op,
  input  logic [SW-1:0] cnt_code,
  input  logic [CW-1:0] reg_lo,
  output logic          armed_q,
  output logic          last_pass
);
  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          armed_d, cnt_en;

  always_comb begin
    load_val = (cnt_code == '0) ? reg_lo : (CW'(1) << cnt_code);
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    cnt_en   = 1'b0;
    unique case (op)
      LP_LOAD: begin cnt_d = load_val; armed_d = (load_val != '0); cnt_en = 1'b1; end
      LP_STEP: begin cnt_d = cnt_q - CW'(1); cnt_en = 1'b1; end
      LP_DONE: begin armed_d = 1'b0; cnt_en = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign last_pass = (cnt_q == CW'(1));

  // R4: a loop-back consumes exactly one pass
  a_r4_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LP_STEP) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R5: the final pass disarms
  a_r5_done_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LP_DONE) |=> !armed_q);
  // R6: zero register count never arms
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LP_LOAD && cnt_code == '0 && reg_lo == '0) |=> !armed_q);
  // R3: power-of-two codes always arm
  a_r3_imm_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LP_LOAD && cnt_code != '0) |=> armed_q);
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl
  import hw_loop_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int CW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] seq_pc,
  input  logic          setup,
  input  logic [SW-1:0] cnt_code,
  input  logic [CW-1:0] reg_lo,
  input  logic [OW-1:0] rel_off,
  output logic [AW-1:0] next_pc,
  output logic          loop_busy
);
  lp_op_e        op;
  logic [AW-1:0] first_q;
  logic          at_last, armed_q, last_pass;

  always_comb begin
    if (setup)                  op = LP_LOAD;
    else if (armed_q && at_last) op = last_pass ? LP_DONE : LP_STEP;
    else                        op = LP_HOLD;
  end

  hw_loop_bounds #(.AW(AW), .OW(OW)) u_bounds (
    .clk(clk), .rst_n(rst_n), .op(op), .cur_pc(cur_pc),
    .rel_off(rel_off), .first_q(first_q), .at_last(at_last)
  );

  hw_loop_count #(.CW(CW), .SW(SW)) u_count (
    .clk(clk), .rst_n(rst_n), .op(op), .cnt_code(cnt_code),
    .reg_lo(reg_lo), .armed_q(armed_q), .last_pass(last_pass)
  );

  assign next_pc   = (op == LP_STEP) ? first_q : seq_pc;
  assign loop_busy = armed_q;

  // R8: nothing armed means the sequential address passes through
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (next_pc == seq_pc));
  // R9: setup never redirects
  a_r9_setup_seq: assert property (@(posedge clk) disable iff (!rst_n)
    setup |-> (next_pc == seq_pc));
  // R5: busy only falls after the last pass at the end address or a setup
  a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_busy) |-> $past(setup || (at_last && last_pass)));
  // R4: loop-back targets the recorded first address
  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && at_last && !last_pass && !setup) |-> (next_pc == first_q));
endmodule

// File: tb/test_hw_loop_ctrl.sv
module test_hw_loop_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cur_pc, seq_pc, next_pc;
  logic        setup, loop_busy;
  logic [2:0]  cnt_code;
  logic [7:0]  reg_lo, rel_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_first, m_last;
  int          m_cnt;
  bit          m_act;

  always #2 clk = ~clk;

  hw_loop_ctrl i_hw_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .seq_pc(seq_pc),
    .setup(setup), .cnt_code(cnt_code), .reg_lo(reg_lo), .rel_off(rel_off),
    .next_pc(next_pc), .loop_busy(loop_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run a program from la until stop; lb is an optional second setup address.
  task automatic run(input logic [15:0] la, input logic [2:0] ca, input logic [7:0] ra,
                     input logic [7:0] oa, input logic [15:0] lb, input logic [2:0] cb,
                     input logic [7:0] rb, input logic [7:0] ob, input logic [15:0] stop,
                     input logic [15:0] probe, output int visits);
    logic [15:0] pc, exp_nxt;
    int n;
    pc = la;
    visits = 0;
    for (int cyc = 0; cyc < 2000 && pc != stop; cyc++) begin
      cur_pc = pc;
      seq_pc = pc + 16'd1;
      setup  = (pc == la) || (pc == lb);
      cnt_code = (pc == lb) ? cb : ca;
      reg_lo   = (pc == lb) ? rb : ra;
      rel_off  = (pc == lb) ? ob : oa;
      if (!setup && m_act && pc == m_last && m_cnt > 1) exp_nxt = m_first;
      else exp_nxt = pc + 16'd1;
      @(negedge clk);
      chk(next_pc == exp_nxt, setup ? "R9 next_pc" : "R4/R8 next_pc", next_pc, exp_nxt);
      chk(loop_busy == m_act, "R5/R6 loop_busy", loop_busy, m_act);
      if (pc == probe) visits++;
      @(posedge clk);
      if (setup) begin
        n = (cnt_code == 3'd0) ? int'(reg_lo) : (1 << cnt_code);
        m_first = pc + 16'd1;
        m_last  = pc + {{8{rel_off[7]}}, rel_off};
        m_cnt   = n;
        m_act   = (n != 0);
      end else if (m_act && pc == m_last) begin
        if (m_cnt > 1) m_cnt--; else m_act = 1'b0;
      end
      pc = exp_nxt;
      #1;
    end
    setup = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; setup = 1'b0; cnt_code = '0; reg_lo = '0; rel_off = '0;
    cur_pc = 16'd5; seq_pc = 16'd6;
    m_first = '0; m_last = '0; m_cnt = 0; m_act = 1'b0;
    #1;
    chk(loop_busy == 1'b0, "R1 busy in reset", loop_busy, 0);
    chk(next_pc == 16'd6, "R1 next_pc in reset", next_pc, 6);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(loop_busy == 1'b0, "R1 busy after reset", loop_busy, 0);
    @(posedge clk); #1;

    run(16'd16, 3'd0, 8'd3, 8'd3, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd20, 16'd17, v);
    chk(v == 3, "R3 register count 3", v, 3);
    run(16'd30, 3'd2, 8'd0, 8'd2, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd33, 16'd31, v);
    chk(v == 4, "R3 code 2 gives 4", v, 4);
    run(16'd50, 3'd7, 8'd0, 8'd1, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd52, 16'd51, v);
    chk(v == 128, "R4 one-instruction body code 7", v, 128);
    run(16'd60, 3'd0, 8'd0, 8'd2, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd63, 16'd61, v);
    chk(v == 1, "R6 zero count runs once", v, 1);
    chk(loop_busy == 1'b0, "R6 not armed", loop_busy, 0);
    run(16'd64, 3'd0, 8'd1, 8'd1, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd66, 16'd65, v);
    chk(v == 1, "R5 count 1 runs once", v, 1);
    run(16'd80, 3'd0, 8'd255, 8'd1, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd82, 16'd81, v);
    chk(v == 255, "R5 count 255", v, 255);
    run(16'd100, 3'd0, 8'd5, 8'd4, 16'd102, 3'd3, 8'd0, 8'd1, 16'd106, 16'd103, v);
    chk(v == 8, "R7 setup inside loop replaces it", v, 8);
    run(16'd120, 3'd0, 8'd3, 8'd4, 16'd124, 3'd1, 8'd0, 8'd2, 16'd127, 16'd121, v);
    chk(v == 1, "R9 setup at last address wins", v, 1);
    run(16'd200, 3'd1, 8'd0, 8'h80, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd210, 16'd201, v);
    chk(v == 1, "R2 negative offset body", v, 1);
    @(negedge clk);
    chk(loop_busy == 1'b1, "R2 loop still armed below", loop_busy, 1);
    @(posedge clk); #1;
    run(16'd16, 3'd0, 8'd3, 8'd3, 16'hFFFF, 3'd0, 8'd0, 8'd0, 16'd20, 16'd17, v);
    chk(v == 3, "R7 new loop over armed one", v, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule